// File: doc/BRIEF.md
# Conflict-Free Bank Selector for an Interleaved Branch Predictor

This block assigns a bank number to every fetch block that looks up a bank-interleaved branch predictor whose storage is split into single-ported banks. Up to two fetch blocks arrive per cycle. The block ensures that any two blocks next to each other in the fetch stream land in different banks. The two blocks issued in one cycle can therefore read their banks without arbitration and without stalls.

A block's bank is derived from two things: two address bits of the block fetched two positions earlier, and the bank already given to the block just before it. If the candidate taken from the address equals the preceding block's bank, its lowest bit is inverted. Inverting a single bit keeps the result inside the bank range and always makes it differ from the preceding bank. The bank numbers and one-hot bank enables are registered, so they are ready one cycle ahead of the table access. A flush reloads the stored history, meaning the two older address bit pairs and the last bank, from restore inputs.

Top module: `bsel_conflict_free`

## Requirements
- R1: After reset, both output valids and enables are 0. The stored history is cleared: both older bank-select pairs and the last bank are 0. The first block after reset is therefore given bank 1.
- R2: A block in slot 0 takes as candidate the bank-select bits (address bits 6:5) of the block two positions earlier in the stream. If that candidate equals the bank of the immediately preceding block, it gets the candidate with bit 0 inverted. Otherwise it gets the candidate unchanged.
- R3: A block in slot 1 takes as candidate the bank-select bits of the last block accepted before this cycle. It compares that candidate against the bank just given to slot 0, using the same inversion rule.
- R4: Each accepted block's bank, enable and valid appear on the outputs in the cycle after the block is presented, and only then.
- R5: Each enable output is the one-hot code of its bank (bit b set for bank b) when its valid is 1, and all zeros otherwise. A bank output reads 0 when its valid is 0.
- R6: The two banks issued in one cycle always differ, and every block's bank differs from the bank of the block accepted just before it.
- R7: A slot 1 block presented without a slot 0 block is ignored. It produces no output and leaves the history unchanged.
- R8: While flush is high, the history is reloaded from the restore inputs and both block inputs are ignored. No valid output follows in the next cycle.
- R9: A cycle with no accepted block and no flush leaves the history unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush_i | input | 1 | Reload history from the restore inputs |
| rst_old_sel_i | input | 2 | Restore value: bank-select bits of the block two positions back |
| rst_new_sel_i | input | 2 | Restore value: bank-select bits of the last block |
| rst_bank_i | input | 2 | Restore value: bank of the last block |
| in0_vld_i | input | 1 | First block of the cycle is present |
| in0_addr_i | input | 16 | First block address |
| in1_vld_i | input | 1 | Second block of the cycle is present |
| in1_addr_i | input | 16 | Second block address |
| out0_vld_o | output | 1 | Registered valid for the first block |
| out0_bank_o | output | 2 | Registered bank for the first block |
| out0_en_o | output | 4 | One-hot bank enable for the first block |
| out1_vld_o | output | 1 | Registered valid for the second block |
| out1_bank_o | output | 2 | Registered bank for the second block |
| out1_en_o | output | 4 | One-hot bank enable for the second block |

## Verification
Every result, whether bank, enable or valid, is due exactly one clock after its blocks are presented, because a single register stage lies between inputs and outputs. History changes take effect on the very next presented block. The bench drives inputs on the falling edge and compares outputs on the following falling edge, after one rising edge has passed. At that point it checks the expectation its model computed from the inputs of the previous cycle. Reset is released through a two-flop synchronizer, so the reset-state checks wait until that has cleared.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
  typedef enum logic [1:0] {
    OCC_NONE  = 2'd0,
    OCC_ONE   = 2'd1,
    OCC_TWO   = 2'd2,
    OCC_FLUSH = 2'd3
  } occ_e;

  function automatic occ_e decode_occ(input logic flush, input logic v0, input logic v1);
    if (flush)         return OCC_FLUSH;
    else if (v0 && v1) return OCC_TWO;
    else if (v0)       return OCC_ONE;
    else               return OCC_NONE;
  endfunction
endpackage

// File: rtl/bsel_rst_sync.sv
module bsel_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/bsel_pick.sv
module bsel_pick #(
  parameter int BANK_W = 2
) (
  input  logic [BANK_W-1:0] cand_i,
  input  logic [BANK_W-1:0] prev_bank_i,
  output logic [BANK_W-1:0] bank_o
);
  logic clash;

  always_comb begin
    clash  = (cand_i == prev_bank_i);
    bank_o = cand_i;
    bank_o[0] = cand_i[0] ^ clash;
  end
endmodule

// File: rtl/bsel_hist.sv
module bsel_hist
  import bsel_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  occ_e              occ_i,
  input  logic [BANK_W-1:0] sel0_i,
  input  logic [BANK_W-1:0] sel1_i,
  input  logic [BANK_W-1:0] bank0_i,
  input  logic [BANK_W-1:0] bank1_i,
  input  logic [BANK_W-1:0] rst_old_i,
  input  logic [BANK_W-1:0] rst_new_i,
  input  logic [BANK_W-1:0] rst_bank_i,
  output logic [BANK_W-1:0] old_sel_o,
  output logic [BANK_W-1:0] new_sel_o,
  output logic [BANK_W-1:0] last_bank_o
);
  logic [BANK_W-1:0] old_d, new_d, bank_d;
  logic              upd_en;

  always_comb begin
    upd_en = (occ_i != OCC_NONE);
    old_d  = old_sel_o;
    new_d  = new_sel_o;
    bank_d = last_bank_o;
    unique case (occ_i)
      OCC_FLUSH: begin
        old_d  = rst_old_i;
        new_d  = rst_new_i;
        bank_d = rst_bank_i;
      end
      OCC_TWO: begin
        old_d  = sel0_i;
        new_d  = sel1_i;
        bank_d = bank1_i;
      end
      OCC_ONE: begin
        old_d  = new_sel_o;
        new_d  = sel0_i;
        bank_d = bank0_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      old_sel_o   <= '0;
      new_sel_o   <= '0;
      last_bank_o <= '0;
    end else if (upd_en) begin
      old_sel_o   <= old_d;
      new_sel_o   <= new_d;
      last_bank_o <= bank_d;
    end
  end
endmodule

// File: rtl/bsel_out.sv
module bsel_out
  import bsel_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  occ_e                 occ_i,
  input  logic [BANK_W-1:0]    bank0_i,
  input  logic [BANK_W-1:0]    bank1_i,
  output logic                 vld0_o,
  output logic [BANK_W-1:0]    bank0_o,
  output logic [NUM_BANKS-1:0] en0_o,
  output logic                 vld1_o,
  output logic [BANK_W-1:0]    bank1_o,
  output logic [NUM_BANKS-1:0] en1_o
);
  logic                 vld0_d, vld1_d;
  logic [BANK_W-1:0]    bank0_d, bank1_d;
  logic [NUM_BANKS-1:0] en0_d, en1_d;

  always_comb begin
    vld0_d  = (occ_i == OCC_ONE) || (occ_i == OCC_TWO);
    vld1_d  = (occ_i == OCC_TWO);
    bank0_d = vld0_d ? bank0_i : '0;
    bank1_d = vld1_d ? bank1_i : '0;
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_dec
    assign en0_d[g] = vld0_d && (bank0_i == BANK_W'(g));
    assign en1_d[g] = vld1_d && (bank1_i == BANK_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld0_o  <= 1'b0;
      bank0_o <= '0;
      en0_o   <= '0;
      vld1_o  <= 1'b0;
      bank1_o <= '0;
      en1_o   <= '0;
    end else begin
      vld0_o  <= vld0_d;
      bank0_o <= bank0_d;
      en0_o   <= en0_d;
      vld1_o  <= vld1_d;
      bank1_o <= bank1_d;
      en1_o   <= en1_d;
    end
  end
endmodule

// File: rtl/bsel_conflict_free.sv
module bsel_conflict_free
  import bsel_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 16,
  parameter int SEL_LSB   = 5,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush_i,
  input  logic [BANK_W-1:0]    rst_old_sel_i,
  input  logic [BANK_W-1:0]    rst_new_sel_i,
  input  logic [BANK_W-1:0]    rst_bank_i,
  input  logic                 in0_vld_i,
  input  logic [ADDR_W-1:0]    in0_addr_i,
  input  logic                 in1_vld_i,
  input  logic [ADDR_W-1:0]    in1_addr_i,
  output logic                 out0_vld_o,
  output logic [BANK_W-1:0]    out0_bank_o,
  output logic [NUM_BANKS-1:0] out0_en_o,
  output logic                 out1_vld_o,
  output logic [BANK_W-1:0]    out1_bank_o,
  output logic [NUM_BANKS-1:0] out1_en_o
);
  localparam int SEL_MSB = SEL_LSB + BANK_W - 1;

  logic              rst_int_n;
  occ_e              occ;
  logic [BANK_W-1:0] sel0, sel1;
  logic [BANK_W-1:0] old_sel, new_sel, last_bank;
  logic [BANK_W-1:0] bank0, bank1;

  bsel_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  always_comb begin
    occ  = decode_occ(flush_i, in0_vld_i, in1_vld_i);
    sel0 = in0_addr_i[SEL_MSB:SEL_LSB];
    sel1 = in1_addr_i[SEL_MSB:SEL_LSB];
  end

  // slot 0: candidate from two blocks back, compared with last bank
  bsel_pick #(.BANK_W(BANK_W)) u_pick0 (
    .cand_i      (old_sel),
    .prev_bank_i (last_bank),
    .bank_o      (bank0)
  );

  // slot 1: candidate from the last block, compared with slot 0's bank
  bsel_pick #(.BANK_W(BANK_W)) u_pick1 (
    .cand_i      (new_sel),
    .prev_bank_i (bank0),
    .bank_o      (bank1)
  );

  bsel_hist #(.BANK_W(BANK_W)) u_hist (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .occ_i       (occ),
    .sel0_i      (sel0),
    .sel1_i      (sel1),
    .bank0_i     (bank0),
    .bank1_i     (bank1),
    .rst_old_i   (rst_old_sel_i),
    .rst_new_i   (rst_new_sel_i),
    .rst_bank_i  (rst_bank_i),
    .old_sel_o   (old_sel),
    .new_sel_o   (new_sel),
    .last_bank_o (last_bank)
  );

  bsel_out #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .occ_i   (occ),
    .bank0_i (bank0),
    .bank1_i (bank1),
    .vld0_o  (out0_vld_o),
    .bank0_o (out0_bank_o),
    .en0_o   (out0_en_o),
    .vld1_o  (out1_vld_o),
    .bank1_o (out1_bank_o),
    .en1_o   (out1_en_o)
  );
endmodule

// File: rtl/bsel_checker.sv
module bsel_checker #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 flush_i,
  input logic                 in0_vld_i,
  input logic                 in1_vld_i,
  input logic                 out0_vld_o,
  input logic [BANK_W-1:0]    out0_bank_o,
  input logic [NUM_BANKS-1:0] out0_en_o,
  input logic                 out1_vld_o,
  input logic [BANK_W-1:0]    out1_bank_o,
  input logic [NUM_BANKS-1:0] out1_en_o
);
  assert_slot_distinct_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out0_vld_o && out1_vld_o) |-> (out0_bank_o != out1_bank_o));

  assert_follow_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out0_vld_o && $past(out0_vld_o) && !$past(out1_vld_o)) |-> (out0_bank_o != $past(out0_bank_o)));

  assert_follow_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out0_vld_o && $past(out1_vld_o)) |-> (out0_bank_o != $past(out1_bank_o)));

  assert_en0_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out0_vld_o |-> ($countones(out0_en_o) == 1));

  assert_en1_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !out1_vld_o |-> (out1_en_o == '0));

  assert_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out0_vld_o |-> $past(in0_vld_i && !flush_i));

  assert_lone_slot1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in1_vld_i && !in0_vld_i) |=> !out1_vld_o);

  assert_flush_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (!out0_vld_o && !out1_vld_o));
endmodule

bind bsel_conflict_free bsel_checker #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_bsel_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush_i     (flush_i),
  .in0_vld_i   (in0_vld_i),
  .in1_vld_i   (in1_vld_i),
  .out0_vld_o  (out0_vld_o),
  .out0_bank_o (out0_bank_o),
  .out0_en_o   (out0_en_o),
  .out1_vld_o  (out1_vld_o),
  .out1_bank_o (out1_bank_o),
  .out1_en_o   (out1_en_o)
);

// File: tb/tb_bsel_conflict_free.sv
module tb_bsel_conflict_free;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 16;
  localparam int LSB = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          flush_i;
  logic [1:0]    rst_old_sel_i, rst_new_sel_i, rst_bank_i;
  logic          in0_vld_i, in1_vld_i;
  logic [AW-1:0] in0_addr_i, in1_addr_i;
  logic          out0_vld_o, out1_vld_o;
  logic [1:0]    out0_bank_o, out1_bank_o;
  logic [3:0]    out0_en_o, out1_en_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // reference state
  int m_old = 0, m_new = 0, m_bank = 0;
  bit pend = 0;
  int e_v0, e_b0, e_v1, e_b1;
  string t0, t1;
  int idle_run = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bsel_conflict_free dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .rst_old_sel_i(rst_old_sel_i), .rst_new_sel_i(rst_new_sel_i), .rst_bank_i(rst_bank_i),
    .in0_vld_i(in0_vld_i), .in0_addr_i(in0_addr_i),
    .in1_vld_i(in1_vld_i), .in1_addr_i(in1_addr_i),
    .out0_vld_o(out0_vld_o), .out0_bank_o(out0_bank_o), .out0_en_o(out0_en_o),
    .out1_vld_o(out1_vld_o), .out1_bank_o(out1_bank_o), .out1_en_o(out1_en_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pick(input int cand, input int prev);
    if (cand == prev) return (cand % 2 == 0) ? cand + 1 : cand - 1;
    return cand;
  endfunction

  task automatic compare();
    int en0, en1;
    if (!pend) return;
    en0 = e_v0 ? (1 << e_b0) : 0;
    en1 = e_v1 ? (1 << e_b1) : 0;
    check(out0_vld_o == e_v0, {t0, " vld0 (R4)"}, out0_vld_o, e_v0);
    check(out0_bank_o == e_b0, {t0, " bank0"}, out0_bank_o, e_b0);
    check(out0_en_o == en0, "R5 en0", out0_en_o, en0);
    check(out1_vld_o == e_v1, {t1, " vld1 (R4)"}, out1_vld_o, e_v1);
    check(out1_bank_o == e_b1, {t1, " bank1"}, out1_bank_o, e_b1);
    check(out1_en_o == en1, "R5 en1", out1_en_o, en1);
    if (out0_vld_o && out1_vld_o)
      check(out0_bank_o != out1_bank_o, "R6 same-cycle banks differ", out1_bank_o, -1);
  endtask

  // compare previous results, drive new inputs, update the model
  task automatic step(input bit f, input bit v0, input int a0, input bit v1, input int a1,
                      input int ro, input int rn, input int rb);
    int c0, c1;
    compare();
    flush_i = f; rst_old_sel_i = 2'(ro); rst_new_sel_i = 2'(rn); rst_bank_i = 2'(rb);
    in0_vld_i = v0; in0_addr_i = AW'(a0); in1_vld_i = v1; in1_addr_i = AW'(a1);
    e_v0 = 0; e_b0 = 0; e_v1 = 0; e_b1 = 0;
    if (f) begin
      t0 = "R8"; t1 = "R8";
      m_old = ro; m_new = rn; m_bank = rb; idle_run = 0;
    end else if (v0) begin
      t0 = (idle_run > 0) ? "R9" : "R2";
      t1 = "R3";
      c0 = (a0 >> LSB) & 3;
      e_v0 = 1; e_b0 = pick(m_old, m_bank);
      if (v1) begin
        c1 = (a1 >> LSB) & 3;
        e_v1 = 1; e_b1 = pick(m_new, e_b0);
        m_old = c0; m_new = c1; m_bank = e_b1;
      end else begin
        m_old = m_new; m_new = c0; m_bank = e_b0;
      end
      idle_run = 0;
    end else begin
      t0 = v1 ? "R7" : "R9"; t1 = t0;
      idle_run++;
    end
    pend = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; flush_i = 0; in0_vld_i = 0; in1_vld_i = 0;
    in0_addr_i = '0; in1_addr_i = '0;
    rst_old_sel_i = '0; rst_new_sel_i = '0; rst_bank_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(out0_vld_o == 0 && out1_vld_o == 0, "R1 reset valids", out0_vld_o + out1_vld_o, 0);
    check(out0_en_o == 0 && out1_en_o == 0, "R1 reset enables", out0_en_o | out1_en_o, 0);
    // first block after reset: cleared history gives bank 1
    step(0, 1, 'h0060, 0, 0, 0, 0, 0);
    check(out0_bank_o == 1, "R1 first bank after reset", out0_bank_o, 1);
    pend = 0;
    // directed: address bits 6:5 = 3 and 2, then a clash case
    step(0, 1, 'h0060, 1, 'h0040, 0, 0, 0);
    step(0, 1, 'h0020, 1, 'h0000, 0, 0, 0);
    step(0, 1, 'h0000, 0, 0, 0, 0, 0);
    // lone slot 1 ignored, then idle, then a block
    step(0, 0, 0, 1, 'h0060, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 1, 'h0040, 0, 0, 0, 0, 0);
    // flush with restore values forcing a clash in slot 0
    step(1, 1, 'h0060, 1, 'h0060, 2, 1, 2);
    step(0, 1, 'h0020, 1, 'h0060, 0, 0, 0);
    step(1, 0, 0, 0, 0, 3, 3, 1);
    step(0, 1, 'h0000, 1, 'h0000, 0, 0, 0);
    // random traffic
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 15);
      step(r == 0, r > 3, $urandom, r > 8, $urandom,
           $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3));
    end
    step(0, 0, 0, 0, 0, 0, 0, 0);
    compare();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule